// File: doc/BRIEF.md
# Precise Trap Controller for a Five-Stage Pipeline

This block decides, every cycle, whether the in-order pipeline must enter its trap handler. Each of the front four stages (fetch, decode, execute, memory) can raise a request in any cycle. The block picks the oldest faulting instruction, which is the one deepest in the pipe. In the same cycle it squashes that instruction and everything younger, and it steers the fetch address to a fixed handler vector. At the following clock edge it records the faulting address, the reason code and the new machine state in three readable registers. Instructions older than the winner are not touched, so they finish normally and the trap stays precise.

An external interrupt line is honoured only at an instruction boundary. The instruction in the memory stage is treated as the next one to run after the handler returns. The interrupt is taken only when the global enable in the state register is set, and only when no synchronous fault is pending. Entering the handler clears that enable, which blocks nesting. A return-from-trap input sets the enable again and sends fetch back to the saved address.

The stage addresses supplied on the inputs are the already incremented fetch addresses that travel down the pipe. The block therefore subtracts 4 before saving one.

Top module: `pipe_trap_unit`

## Requirements
- R1: After reset the saved-address register and the reason register read 0. The state register reads 1 (bit 0 = interrupt enable set, bit 1 = in-handler flag clear). No flush or redirect is driven.
- R2: When several stages request in one cycle, the deepest one wins. Priority runs memory, then execute, then decode, then fetch.
- R3: `flush` bit 0 is fetch, bit 1 is decode, bit 2 is execute and bit 3 is memory. In a trap cycle the winning stage's bit and every bit below it are 1. All higher bits are 0. All bits are combinational in the request cycle.
- R4: In the cycle a trap is taken, `redirect` is 1 and `redirect_pc` equals 0x8000_0180.
- R5: At the clock edge ending a trap cycle, the saved-address register loads the winning stage's address minus 4.
- R6: The reason register holds a 5-bit code in bits [6:2], and every other bit reads 0. The codes are: fetch fault 4, memory fault on a load 4, memory fault on a store 5, decode fault 10, execute fault 12, interrupt 0.
- R7: An interrupt is taken only when `irq`=1, `mem_valid`=1, the enable bit is 1 and no stage requests a fault. It then flushes all four stages, saves `pc_mem`-4 and records code 0. In every other case it has no effect.
- R8: Taking any trap clears the enable bit (bit 0) and sets the in-handler flag (bit 1) of the state register.
- R9: `eret` without a trap in the same cycle drives `redirect`=1 with `redirect_pc` equal to the saved address and no flush. At the edge it sets the enable bit and clears the in-handler flag. When a trap occurs in the same cycle, the trap wins.
- R10: With no request, no eligible interrupt and no `eret`, there is no flush and no redirect, and all three registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_req | input | 1 | Fetch-stage fault (page, alignment or protection) |
| id_req | input | 1 | Decode-stage fault (undefined opcode) |
| ex_req | input | 1 | Execute-stage fault (arithmetic overflow) |
| mem_req | input | 1 | Memory-stage fault (page, alignment or protection) |
| mem_store | input | 1 | Memory-stage instruction is a store |
| mem_valid | input | 1 | Memory stage holds a real instruction |
| pc_if | input | 32 | Incremented address of the fetch-stage instruction |
| pc_id | input | 32 | Incremented address of the decode-stage instruction |
| pc_ex | input | 32 | Incremented address of the execute-stage instruction |
| pc_mem | input | 32 | Incremented address of the memory-stage instruction |
| irq | input | 1 | External interrupt, already synchronous to clk |
| eret | input | 1 | Return from handler |
| flush | output | 4 | Per-stage squash (zero control signals) |
| redirect | output | 1 | Override next fetch address |
| redirect_pc | output | 32 | Next fetch address when redirect is 1 |
| epc | output | 32 | Saved faulting address |
| cause | output | 32 | Reason register |
| status | output | 32 | State register |

## Verification
The bench aims at requests from several stages in one cycle. A design that scanned the stages the wrong way would let a younger fault win and would flush an older instruction that should have retired. It also raises an interrupt while the enable bit is clear, while the memory stage is empty, and while a decode fault is pending. An ungated design would take a trap there with code 0. A return that coincides with a fault must not re-enable interrupts, and a saved address missing the minus-4 correction shows up on every trap.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam int NSTG = 4;
    localparam int IDXW = $clog2(NSTG);
    localparam int CODEW = 5;

    localparam int STG_IF  = 0;
    localparam int STG_ID  = 1;
    localparam int STG_EX  = 2;
    localparam int STG_MEM = 3;

    typedef enum logic [CODEW-1:0] {
        EC_IRQ     = 5'd0,
        EC_ADDR_LD = 5'd4,
        EC_ADDR_ST = 5'd5,
        EC_RSVD    = 5'd10,
        EC_OVF     = 5'd12
    } exc_code_e;

    typedef struct packed {
        logic [31:0]      epc;
        logic [CODEW-1:0] code;
        logic             ie;
        logic             exl;
    } trap_regs_t;
endpackage

// File: rtl/trap_select.sv
module trap_select
    import trap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [NSTG-1:0]           req,
    input  logic [NSTG-1:0][XLEN-1:0] pc,
    output logic                      hit,
    output logic [IDXW-1:0]           idx,
    output logic [XLEN-1:0]           pc_sel
);
    // Later (deeper) stages overwrite earlier ones: oldest instruction wins.
    always_comb begin
        hit    = 1'b0;
        idx    = '0;
        pc_sel = pc[0];
        for (int i = 0; i < NSTG; i++) begin
            if (req[i]) begin
                hit    = 1'b1;
                idx    = IDXW'(i);
                pc_sel = pc[i];
            end
        end
    end
endmodule

// File: rtl/trap_flush_gen.sv
module trap_flush_gen
    import trap_pkg::*;
(
    input  logic            take,
    input  logic [IDXW-1:0] idx,
    output logic [NSTG-1:0] flush
);
    for (genvar g = 0; g < NSTG; g++) begin : g_stage
        assign flush[g] = take && (IDXW'(g) <= idx);
    end
endmodule

// File: rtl/pipe_trap_unit.sv
module pipe_trap_unit
    import trap_pkg::*;
#(
    parameter int          XLEN      = 32,
    parameter logic [31:0] VECTOR    = 32'h8000_0180,
    parameter logic        IE_RESET  = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            if_req,
    input  logic            id_req,
    input  logic            ex_req,
    input  logic            mem_req,
    input  logic            mem_store,
    input  logic            mem_valid,
    input  logic [XLEN-1:0] pc_if,
    input  logic [XLEN-1:0] pc_id,
    input  logic [XLEN-1:0] pc_ex,
    input  logic [XLEN-1:0] pc_mem,
    input  logic            irq,
    input  logic            eret,
    output logic [NSTG-1:0] flush,
    output logic            redirect,
    output logic [XLEN-1:0] redirect_pc,
    output logic [XLEN-1:0] epc,
    output logic [XLEN-1:0] cause,
    output logic [XLEN-1:0] status
);
    localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

    logic [NSTG-1:0]           stage_req;
    logic [NSTG-1:0][XLEN-1:0] stage_pc;
    logic                      sync_hit;
    logic [IDXW-1:0]           sync_idx;
    logic [XLEN-1:0]           sync_pc;
    logic                      irq_take;
    logic                      take;
    logic [IDXW-1:0]           win_idx;
    logic [XLEN-1:0]           win_pc;
    logic [CODEW-1:0]          win_code;
    trap_regs_t                r_d, r_q;

    assign stage_req = {mem_req, ex_req, id_req, if_req};
    assign stage_pc  = {pc_mem, pc_ex, pc_id, pc_if};

    trap_select #(.XLEN(XLEN)) u_select (
        .req    (stage_req),
        .pc     (stage_pc),
        .hit    (sync_hit),
        .idx    (sync_idx),
        .pc_sel (sync_pc)
    );

    trap_flush_gen u_flush (
        .take  (take),
        .idx   (win_idx),
        .flush (flush)
    );

    always_comb begin
        irq_take = irq && r_q.ie && mem_valid && !sync_hit;
        take     = sync_hit || irq_take;
        win_idx  = sync_hit ? sync_idx : IDXW'(STG_MEM);
        win_pc   = sync_hit ? sync_pc  : pc_mem;

        unique case (int'(win_idx))
            STG_MEM: win_code = mem_store ? EC_ADDR_ST : EC_ADDR_LD;
            STG_EX:  win_code = EC_OVF;
            STG_ID:  win_code = EC_RSVD;
            default: win_code = EC_ADDR_LD;
        endcase
        if (!sync_hit) win_code = EC_IRQ;

        r_d = r_q;
        if (take) begin
            r_d.epc  = 32'(win_pc - INSN_BYTES);
            r_d.code = win_code;
            r_d.ie   = 1'b0;
            r_d.exl  = 1'b1;
        end else if (eret) begin
            r_d.ie   = 1'b1;
            r_d.exl  = 1'b0;
        end

        redirect    = take || eret;
        redirect_pc = take ? XLEN'(VECTOR) : XLEN'(r_q.epc);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.epc  <= '0;
            r_q.code <= '0;
            r_q.ie   <= IE_RESET;
            r_q.exl  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign epc    = XLEN'(r_q.epc);
    assign cause  = XLEN'({r_q.code, 2'b00});
    assign status = XLEN'({r_q.exl, r_q.ie});
endmodule

// File: rtl/pipe_trap_unit_chk.sv
module pipe_trap_unit_chk
    import trap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            if_req,
    input logic            id_req,
    input logic            ex_req,
    input logic            mem_req,
    input logic            mem_valid,
    input logic [XLEN-1:0] pc_mem,
    input logic            irq,
    input logic            eret,
    input logic [NSTG-1:0] flush,
    input logic            redirect,
    input logic [XLEN-1:0] redirect_pc,
    input logic [XLEN-1:0] epc,
    input logic [XLEN-1:0] cause,
    input logic [XLEN-1:0] status
);
    logic any_req;
    logic quiet;
    assign any_req = if_req || id_req || ex_req || mem_req;
    assign quiet   = !any_req && !eret && !(irq && status[0] && mem_valid);

    assert_flush_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flush inside {4'b0000, 4'b0001, 4'b0011, 4'b0111, 4'b1111});

    assert_vector_R4: assert property (@(posedge clk) disable iff (!rst_n)
        flush[0] |-> (redirect && redirect_pc == XLEN'(32'h8000_0180)));

    assert_mem_epc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> (epc == $past(pc_mem) - XLEN'(4)));

    assert_cause_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cause[1:0] == 2'b00) && (cause[XLEN-1:7] == '0));

    assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flush[0] && !any_req) |-> (irq && status[0] && mem_valid));

    assert_entry_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush[0] |=> (status[0] == 1'b0 && status[1] == 1'b1));

    assert_eret_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eret && flush == '0) |=> (status[0] == 1'b1 && status[1] == 1'b0));

    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |=> ($stable(epc) && $stable(cause) && $stable(status)));
endmodule

bind pipe_trap_unit pipe_trap_unit_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/pipe_trap_unit_bench.sv
module pipe_trap_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        if_req, id_req, ex_req, mem_req, mem_store, mem_valid, irq, eret;
    logic [31:0] pc_if, pc_id, pc_ex, pc_mem;
    logic [3:0]  flush;
    logic        redirect;
    logic [31:0] redirect_pc, epc, cause, status;

    int checks = 0;
    int errors = 0;

    // reference state
    logic [31:0] m_epc;
    logic [4:0]  m_code;
    logic        m_ie, m_exl;

    always #10 clk = ~clk;

    pipe_trap_unit u_pipe_trap_unit (
        .clk, .rst_n, .if_req, .id_req, .ex_req, .mem_req, .mem_store, .mem_valid,
        .pc_if, .pc_id, .pc_ex, .pc_mem, .irq, .eret,
        .flush, .redirect, .redirect_pc, .epc, .cause, .status
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_regs(string tag);
        check({tag, "/R5 epc"}, epc, m_epc);
        check({tag, "/R6 cause"}, cause, {25'd0, m_code, 2'b00});
        check({tag, "/R8 status"}, status, {30'd0, m_exl, m_ie});
    endtask

    task automatic drive(logic f, logic d, logic x, logic m, logic st, logic mv,
                         logic ir, logic er);
        if_req = f; id_req = d; ex_req = x; mem_req = m;
        mem_store = st; mem_valid = mv; irq = ir; eret = er;
    endtask

    // one clock: compare combinational outputs mid-cycle, then registers after edge
    task automatic run_cycle(string tag);
        int          w;
        logic        take;
        logic [3:0]  e_flush;
        logic [31:0] e_pc;
        logic [4:0]  e_code;
        @(negedge clk);
        if (mem_req)     begin w = 3; e_pc = pc_mem; e_code = mem_store ? 5'd5 : 5'd4; end
        else if (ex_req) begin w = 2; e_pc = pc_ex;  e_code = 5'd12; end
        else if (id_req) begin w = 1; e_pc = pc_id;  e_code = 5'd10; end
        else if (if_req) begin w = 0; e_pc = pc_if;  e_code = 5'd4;  end
        else if (irq && m_ie && mem_valid) begin w = 3; e_pc = pc_mem; e_code = 5'd0; end
        else begin w = -1; e_pc = 0; e_code = 0; end
        take    = (w >= 0);
        e_flush = take ? 4'((1 << (w + 1)) - 1) : 4'd0;
        check({tag, "/R3 flush"}, 32'(flush), 32'(e_flush));
        check({tag, "/R4 redirect"}, 32'(redirect), 32'(take || eret));
        if (take)      check({tag, "/R4 target"}, redirect_pc, 32'h8000_0180);
        else if (eret) check({tag, "/R9 target"}, redirect_pc, m_epc);
        @(posedge clk);
        if (take) begin
            m_epc = e_pc - 32'd4; m_code = e_code; m_ie = 1'b0; m_exl = 1'b1;
        end else if (eret) begin
            m_ie = 1'b1; m_exl = 1'b0;
        end
        #2;
        check_regs(tag);
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        drive(0, 0, 0, 0, 0, 0, 0, 0);
        pc_if = 32'h0000_0058; pc_id = 32'h0000_0054; pc_ex = 32'h0000_0050; pc_mem = 32'h0000_004C;
        m_epc = 0; m_code = 0; m_ie = 1'b1; m_exl = 1'b0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        check("R1 flush", 32'(flush), 32'd0);
        check("R1 redirect", 32'(redirect), 32'd0);
        check_regs("R1");

        run_cycle("R10 idle");
        drive(1, 0, 0, 0, 0, 1, 0, 0); run_cycle("R2 fetch");
        drive(0, 0, 0, 0, 0, 1, 0, 1); run_cycle("R9 return");
        drive(0, 1, 0, 0, 0, 1, 0, 0); run_cycle("R2 decode");
        drive(0, 0, 1, 0, 0, 1, 0, 0); run_cycle("R2 execute");
        drive(0, 0, 0, 1, 1, 1, 0, 0); run_cycle("R6 store");
        drive(0, 0, 0, 1, 0, 1, 0, 0); run_cycle("R6 load");
        pc_mem = 32'h0000_1004;
        drive(1, 1, 1, 1, 1, 1, 0, 0); run_cycle("R2 all");
        drive(1, 1, 1, 0, 0, 1, 0, 0); run_cycle("R2 three");
        drive(0, 0, 0, 0, 0, 1, 1, 0); run_cycle("R7 disabled");
        drive(0, 0, 0, 0, 0, 1, 0, 1); run_cycle("R9 reenable");
        drive(0, 0, 0, 0, 0, 0, 1, 0); run_cycle("R7 no boundary");
        drive(0, 1, 0, 0, 0, 1, 1, 0); run_cycle("R7 fault first");
        drive(0, 0, 0, 0, 0, 1, 0, 1); run_cycle("R9 reenable2");
        drive(0, 0, 0, 0, 0, 1, 1, 0); run_cycle("R7 taken");
        drive(0, 0, 0, 0, 0, 1, 0, 1); run_cycle("R9 reenable3");
        drive(0, 0, 1, 0, 0, 1, 0, 1); run_cycle("R9 fault wins");
        drive(0, 0, 0, 0, 0, 0, 0, 0); run_cycle("R10 hold");

        for (int n = 0; n < 400; n++) begin
            logic [31:0] r;
            r = $urandom;
            pc_if  = {$urandom} & 32'hFFFF_FFFC;
            pc_id  = {$urandom} & 32'hFFFF_FFFC;
            pc_ex  = {$urandom} & 32'hFFFF_FFFC;
            pc_mem = {$urandom} & 32'hFFFF_FFFC;
            drive(r[2:0] == 0, r[5:3] == 0, r[8:6] == 0, r[11:9] == 0, r[12],
                  r[13] | r[14], r[15] | r[16], r[19:17] == 0);
            run_cycle("R2 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule